// File: doc/BRIEF.md
# Corrected-Code DAC Channel Controller

This block sits between a host-side register interface and a bank of 40 twelve-bit converter channels. Each channel keeps an input code, a gain word and an offset word. A single shared multiplier turns them into a corrected code, one channel at a time, in the order the writes arrived. While any recalculation is pending, the active-low ready flag `busy_n` stays low. Writes are still taken during that time.

Corrected codes reach the output registers only on a load event on `ldac_n`. A load request that arrives too early is held until the queue drains. In normal mode a channel's output is reloaded only when its corrected code was refreshed since the previous load. Channels are grouped in eights, and a group can be put in toggle mode. In toggle mode every load swaps the output between a primary (A) and a secondary (B) code.

A set of special-function addresses provides clear to a programmable code, soft reset, power-down and power-up, a control word, and a monitor channel selector.

Top module: `dacc_core`

## Requirements
- R1: After `rst` every `dac_code` field is 0, `busy_n` is 1, `ctrl_q` is 0x800, `mon_sel` is 63 and `pdown` is 0.
- R2: The corrected code is floor(x1·(m+2)/4096) + c − 2048, clamped to the range 0..4095. Gain m resets to 0xFFE and always has bit 0 cleared. Offset c resets to 0x800, so a channel with default m and c reproduces x1.
- R3: A write with `wr_reg`=3 (input code), 1 (gain) or 2 (offset) to channel `wr_addr`<40 makes `busy_n` low from the next cycle. It stays low until every queued recalculation (CALC_CYC cycles each) has finished. Further writes are accepted during that time.
- R4: A falling edge on `ldac_n` while `busy_n` is low is held and applied once `busy_n` returns high. With `ldac_n` held low, a load happens each time `busy_n` rises.
- R5: In normal mode, a load copies a channel's corrected A code into its output only if that code was recomputed since the previous load. Other outputs keep their value.
- R6: Control bit k (k=0..4) enables toggle mode for channels 8k..8k+7. A write with `wr_ab`=1 stores to the B input code and is ignored unless the channel's group is in toggle mode. In toggle mode the first load shows A, then each load alternates. The first load after toggle is disabled shows A.
- R7: Special address 0x01 (`wr_reg`=0) sets the clear code, which is 0 after reset. Special address 0x02, or `clr_n` low, loads the clear code into every output.
- R8: Special address 0x0F and a `hrst` pulse restore every register to its reset value and zero all outputs. Both are ignored while powered down.
- R9: Special address 0x08 enters power-down (`pdown`=1) and 0x09 leaves it. While powered down, every write other than 0x09 is rejected. Special address 0x0C writes the control word, which is visible on `ctrl_q`.
- R10: Special address 0x0A takes a channel number from `wr_data`[11:6]. `mon_sel` shows it only while control bit 7 is 1 and the number is below 40; otherwise `mon_sel` is 63 (output disconnected).
- R11: Writes to channel addresses 40..63 change nothing and start no recalculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_reg | input | 2 | Target: 0 special, 1 gain, 2 offset, 3 input code |
| wr_ab | input | 1 | Input code bank: 0 = A, 1 = B |
| wr_addr | input | 6 | Channel number or special-function address |
| wr_data | input | 12 | Write data |
| ldac_n | input | 1 | Active-low output load request |
| clr_n | input | 1 | Active-low clear to the clear code |
| hrst | input | 1 | Hardware reset request, ignored in power-down |
| dac_code | output | 480 | Output codes, channel k at bits 12k+11..12k |
| busy_n | output | 1 | Low while recalculations are pending |
| mon_sel | output | 6 | Monitored channel, 63 when disconnected |
| ctrl_q | output | 12 | Control word readback |
| pdown | output | 1 | Power-down state |

## Verification
The bench targets load requests that land while recalculations are still pending. A design that applies them early shows stale codes, and one that drops them never updates. After a clear, it loads a mix of refreshed and untouched channels, so a design that reloads every channel overwrites the clear code. It walks a toggle group through A, B and back to A, including a B write made before the group was enabled; a wrong design shows B first or keeps the rejected value. It also checks clamping at both ends of the range, the cleared gain LSB, and that reset, writes and the control word stay frozen while powered down.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    RG_SPEC = 2'd0,
    RG_GAIN = 2'd1,
    RG_OFFS = 2'd2,
    RG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [5:0] {
    SF_NOP     = 6'h00,
    SF_CLRCODE = 6'h01,
    SF_SOFTCLR = 6'h02,
    SF_PDOWN   = 6'h08,
    SF_PUP     = 6'h09,
    SF_MON     = 6'h0A,
    SF_CTRL    = 6'h0C,
    SF_SRST    = 6'h0F
  } sfr_e;

  localparam int unsigned MON_EN_BIT = 7;
  localparam logic [5:0]  MON_OFF    = 6'h3F;
endpackage

// File: rtl/dacc_corr.sv
module dacc_corr #(
  parameter int W = 12
) (
  input  logic [W-1:0] x1,
  input  logic [W-1:0] m,
  input  logic [W-1:0] c,
  output logic [W-1:0] x2
);
  localparam int PW   = 2*W + 1;
  localparam int MIDV = 1 << (W-1);
  localparam int MAXV = (1 << W) - 1;
  localparam logic signed [W+2:0] MIDS = (W+3)'(MIDV);
  localparam logic signed [W+2:0] MAXS = (W+3)'(MAXV);

  logic [PW-1:0]         prod;
  logic [W:0]            scl;
  logic signed [W+2:0]   sum;

  always_comb begin
    prod = PW'(x1) * PW'({1'b0, m} + (W+1)'(2));
    scl  = prod[2*W:W];
    sum  = $signed({2'b00, scl}) + $signed({3'b000, c}) - MIDS;
    if (sum < 0)         x2 = '0;
    else if (sum > MAXS) x2 = '1;
    else                 x2 = sum[W-1:0];
  end
endmodule

// File: rtl/dacc_recalc_seq.sv
module dacc_recalc_seq #(
  parameter int NCH      = 40,
  parameter int CALC_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [$clog2(NCH)-1:0]   push_ch,
  output logic [$clog2(NCH)-1:0]   ch_o,
  output logic                     ph_a,
  output logic                     ph_b,
  output logic                     done,
  output logic                     idle
);
  localparam int AW  = $clog2(NCH);
  localparam int CNW = $clog2(NCH+1);
  localparam int PHW = $clog2(CALC_CYC);

  logic [AW-1:0]  mem [NCH];
  logic [AW-1:0]  wp, rp;
  logic [CNW-1:0] cnt;
  logic [NCH-1:0] pend;
  logic           act;
  logic [PHW-1:0] phc;
  logic           do_push, pop;

  assign do_push = push && !pend[push_ch];
  assign pop     = !act && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_ch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; cnt <= '0; pend <= '0;
      act <= 1'b0; phc <= '0; ch_o <= '0;
    end else begin
      if (do_push) begin
        wp <= (wp == AW'(NCH-1)) ? '0 : wp + 1'b1;
        pend[push_ch] <= 1'b1;
      end
      if (pop) begin
        rp   <= (rp == AW'(NCH-1)) ? '0 : rp + 1'b1;
        act  <= 1'b1;
        phc  <= '0;
        ch_o <= mem[rp];
        pend[mem[rp]] <= 1'b0;
      end else if (act) begin
        if (phc == PHW'(CALC_CYC-1)) act <= 1'b0;
        else                         phc <= phc + 1'b1;
      end
      cnt <= cnt + CNW'(do_push) - CNW'(pop);
    end
  end

  assign ph_a = act && (phc == '0);
  assign ph_b = act && (phc == PHW'(1));
  assign done = act && (phc == PHW'(CALC_CYC-1));
  assign idle = !act && (cnt == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNW'(NCH)); // R3
  AST_BUSY_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |=> !idle); // R3
endmodule

// File: rtl/dacc_update.sv
module dacc_update #(
  parameter int NCH = 40,
  parameter int W   = 12,
  parameter int GRP = 8,
  parameter int NG  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    apply,
  input  logic                    clr,
  input  logic [NG-1:0]           tog_en,
  input  logic [NCH-1:0]          dirty,
  input  logic [NCH-1:0][W-1:0]   x2a,
  input  logic [NCH-1:0][W-1:0]   x2b,
  input  logic [W-1:0]            clr_code,
  output logic [NCH-1:0][W-1:0]   dac
);
  logic [NCH-1:0] nb;   // next toggle load takes B
  logic [NCH-1:0] onb;  // output currently shows B

  always_ff @(posedge clk) begin
    if (rst) begin
      dac <= '0; nb <= '0; onb <= '0;
    end else if (clr) begin
      for (int i = 0; i < NCH; i++) dac[i] <= clr_code;
      onb <= '0;
    end else if (apply) begin
      for (int i = 0; i < NCH; i++) begin
        if (tog_en[i/GRP]) begin
          dac[i] <= nb[i] ? x2b[i] : x2a[i];
          nb[i]  <= ~nb[i];
          onb[i] <= nb[i];
        end else begin
          nb[i]  <= 1'b0;
          onb[i] <= 1'b0;
          if (dirty[i] || onb[i]) dac[i] <= x2a[i];
        end
      end
    end
  end

  AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(clr || apply) |=> $stable(dac)); // R5
endmodule

// File: rtl/dacc_core.sv
module dacc_core
  import dacc_pkg::*;
#(
  parameter int NCH      = 40,
  parameter int W        = 12,
  parameter int GRP      = 8,
  parameter int CALC_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_reg,
  input  logic             wr_ab,
  input  logic [5:0]       wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             ldac_n,
  input  logic             clr_n,
  input  logic             hrst,
  output logic [NCH*W-1:0] dac_code,
  output logic             busy_n,
  output logic [5:0]       mon_sel,
  output logic [W-1:0]     ctrl_q,
  output logic             pdown
);
  localparam int NG  = (NCH + GRP - 1) / GRP;
  localparam int CHW = $clog2(NCH);
  localparam int GW  = (NG > 1) ? $clog2(NG) : 1;
  localparam logic [W-1:0] GAIN_RST = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] MID_CODE = W'(1) << (W-1);

  logic [NCH-1:0][W-1:0] x1a, x1b, mg, of, x2a, x2b, dac;
  logic [NCH-1:0] dirty;
  logic [W-1:0]   ctrl, clr_code, corr_o, corr_x1;
  logic [5:0]     mon_ch, mon_q;
  logic           pd_q, ldac_d, idle_d, ld_pend;
  logic [CHW-1:0] ch, sch;
  logic [GW-1:0]  grp;
  logic [NG-1:0]  tog_en;
  logic acc, ch_ok, sfr, wa, wb, wg, wo, push;
  logic soft_rst, clr, rst_all, fall, apply;
  logic ph_a, ph_b, done, idle;

  assign tog_en = ctrl[NG-1:0];
  assign ch     = wr_addr[CHW-1:0];
  assign grp    = GW'(ch / CHW'(GRP));
  assign acc    = wr_en && (!pd_q || (wr_reg == RG_SPEC && wr_addr == SF_PUP));
  assign ch_ok  = wr_addr < 6'(NCH);
  assign sfr    = acc && wr_reg == RG_SPEC;
  assign wa     = acc && ch_ok && wr_reg == RG_DATA && !wr_ab;
  assign wb     = acc && ch_ok && wr_reg == RG_DATA && wr_ab && tog_en[grp];
  assign wg     = acc && ch_ok && wr_reg == RG_GAIN;
  assign wo     = acc && ch_ok && wr_reg == RG_OFFS;
  assign push   = wa || wb || wg || wo;

  assign soft_rst = sfr && wr_addr == SF_SRST;
  assign clr      = (sfr && wr_addr == SF_SOFTCLR) || !clr_n;
  assign rst_all  = rst || soft_rst || (hrst && !pd_q);

  assign fall  = ldac_d && !ldac_n;
  assign apply = idle && (ld_pend || fall || (!idle_d && !ldac_n));

  dacc_recalc_seq #(.NCH(NCH), .CALC_CYC(CALC_CYC)) u_seq (
    .clk(clk), .rst(rst_all), .push(push), .push_ch(ch),
    .ch_o(sch), .ph_a(ph_a), .ph_b(ph_b), .done(done), .idle(idle)
  );

  assign corr_x1 = ph_b ? x1b[sch] : x1a[sch];

  dacc_corr #(.W(W)) u_corr (
    .x1(corr_x1), .m(mg[sch]), .c(of[sch]), .x2(corr_o)
  );

  dacc_update #(.NCH(NCH), .W(W), .GRP(GRP), .NG(NG)) u_upd (
    .clk(clk), .rst(rst_all), .apply(apply), .clr(clr), .tog_en(tog_en),
    .dirty(dirty), .x2a(x2a), .x2b(x2b), .clr_code(clr_code), .dac(dac)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      for (int i = 0; i < NCH; i++) begin
        x1a[i] <= '0; x1b[i] <= '0; x2a[i] <= '0; x2b[i] <= '0;
        mg[i]  <= GAIN_RST; of[i] <= MID_CODE;
      end
      dirty <= '0; ctrl <= MID_CODE; clr_code <= '0;
      mon_ch <= MON_OFF; mon_q <= MON_OFF; pd_q <= 1'b0;
      ldac_d <= 1'b1; idle_d <= 1'b1; ld_pend <= 1'b0;
    end else begin
      if (wa) x1a[ch] <= wr_data;
      if (wb) x1b[ch] <= wr_data;
      if (wg) mg[ch]  <= {wr_data[W-1:1], 1'b0};
      if (wo) of[ch]  <= wr_data;
      if (sfr) begin
        case (wr_addr)
          SF_CLRCODE: clr_code <= wr_data;
          SF_PDOWN:   pd_q     <= 1'b1;
          SF_PUP:     pd_q     <= 1'b0;
          SF_MON:     mon_ch   <= wr_data[W-1:W-6];
          SF_CTRL:    ctrl     <= wr_data;
          default: ;
        endcase
      end
      if (ph_a) x2a[sch] <= corr_o;
      if (ph_b) x2b[sch] <= corr_o;
      if (apply)     dirty      <= '0;
      else if (done) dirty[sch] <= 1'b1;
      ldac_d  <= ldac_n;
      idle_d  <= idle;
      ld_pend <= apply ? 1'b0 : (ld_pend || fall);
      mon_q   <= (ctrl[MON_EN_BIT] && mon_ch < 6'(NCH)) ? mon_ch : MON_OFF;
    end
  end

  assign dac_code = dac;
  assign busy_n   = idle;
  assign mon_sel  = mon_q;
  assign ctrl_q   = ctrl;
  assign pdown    = pd_q;

  AST_MON_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctrl[MON_EN_BIT] |=> mon_sel == MON_OFF); // R10
  AST_PDOWN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    pd_q |=> $stable(x1a) && $stable(mg) && $stable(of)); // R9
endmodule

// File: tb/dacc_core_tb.sv
`timescale 1ns/1ps
module dacc_core_tb;
  localparam int NCH = 40;
  localparam int W   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_ab = 1'b0, ldac_n = 1'b1, clr_n = 1'b1, hrst = 1'b0;
  logic [1:0] wr_reg = '0;
  logic [5:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [NCH*W-1:0] dac_code;
  logic busy_n, pdown;
  logic [5:0] mon_sel;
  logic [W-1:0] ctrl_q;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int mx1[NCH], mm[NCH], mc[NCH], mdac[NCH];
  bit mdirty[NCH];

  always #2.5 clk = ~clk;

  dacc_core u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_reg(wr_reg), .wr_ab(wr_ab),
    .wr_addr(wr_addr), .wr_data(wr_data), .ldac_n(ldac_n), .clr_n(clr_n),
    .hrst(hrst), .dac_code(dac_code), .busy_n(busy_n), .mon_sel(mon_sel),
    .ctrl_q(ctrl_q), .pdown(pdown)
  );

  function automatic int exp_x2(int x1, int m, int c);
    int s;
    s = ((x1 * (m + 2)) >> 12) + c - 2048;
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  function automatic int dac_of(int ch);
    return int'(dac_code[ch*W +: W]);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int rg, input bit ab, input int addr, input int data);
    wr_en = 1'b1; wr_reg = rg[1:0]; wr_ab = ab; wr_addr = addr[5:0]; wr_data = data[W-1:0];
    @(negedge clk);
    wr_en = 1'b0; wr_ab = 1'b0;
  endtask

  task automatic wr_ch(input int rg, input int addr, input int data);
    wr(rg, 1'b0, addr, data);
    if (addr < NCH) begin
      if (rg == 1) mm[addr] = data & 'hFFE;
      if (rg == 2) mc[addr] = data;
      if (rg == 3) mx1[addr] = data;
      mdirty[addr] = 1;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_n !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic model_apply();
    for (int i = 0; i < NCH; i++)
      if (mdirty[i]) begin mdac[i] = exp_x2(mx1[i], mm[i], mc[i]); mdirty[i] = 0; end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      mx1[i] = 0; mm[i] = 'hFFE; mc[i] = 'h800; mdac[i] = 0; mdirty[i] = 0;
    end
  endtask

  task automatic ldac_pulse();
    ldac_n = 1'b0; tick(); ldac_n = 1'b1;
    wait_idle(); tick(3);
    model_apply();
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NCH; i++) chk(tag, dac_of(i), mdac[i]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd20220923);
    model_reset();
    tick(5); rst = 1'b0; tick();

    // R1 reset state
    for (int i = 0; i < NCH; i++) chk("R1 dac", dac_of(i), 0);
    chk("R1 busy_n", busy_n, 1);
    chk("R1 ctrl", ctrl_q, 'h800);
    chk("R1 mon", mon_sel, 63);
    chk("R1 pdown", pdown, 0);

    // R11 out-of-range channel
    wr(3, 0, 50, 'h555);
    chk("R11 no busy", busy_n, 1);
    tick(CALC_WAIT());
    check_all("R11 outputs");

    // R3 busy and writes during busy, R2 identity
    wr_ch(3, 5, 'h123);
    chk("R3 busy low", busy_n, 0);
    wr_ch(3, 6, 'h9AB);
    chk("R3 still busy", busy_n, 0);
    wait_idle();
    chk("R3 busy high", busy_n, 1);
    ldac_pulse();
    chk("R2 identity", dac_of(5), 'h123);
    check_all("R3 outputs");

    // R2 gain LSB and clamping
    wr_ch(1, 7, 'h801); wr_ch(3, 7, 'hFFF);
    wr_ch(2, 30, 'hFFF); wr_ch(3, 30, 'hFFF);
    wr_ch(2, 31, 'h000); wr_ch(3, 31, 'h100);
    wait_idle(); ldac_pulse();
    chk("R2 gain lsb", dac_of(7), 2049);
    chk("R2 clamp high", dac_of(30), 4095);
    chk("R2 clamp low", dac_of(31), 0);
    check_all("R2 outputs");

    // R4 deferred load
    wr_ch(3, 5, 'h2AA);
    ldac_n = 1'b0; tick(); ldac_n = 1'b1;
    chk("R4 not early", dac_of(5), 'h123);
    wait_idle(); tick(3); model_apply();
    chk("R4 deferred", dac_of(5), 'h2AA);

    // R4 held low
    ldac_n = 1'b0; tick(3);
    wr_ch(3, 20, 'h5A5); wait_idle(); tick(3); model_apply();
    chk("R4 held 1", dac_of(20), 'h5A5);
    wr_ch(3, 20, 'h0F0); wait_idle(); tick(3); model_apply();
    chk("R4 held 2", dac_of(20), 'h0F0);
    ldac_n = 1'b1; tick(2);

    // R7 clear, R5 selective reload
    wr(0, 0, 'h01, 'hABC);
    wr(0, 0, 'h02, 0); tick();
    for (int i = 0; i < NCH; i++) mdac[i] = 'hABC;
    check_all("R7 soft clear");
    wr_ch(3, 3, 'h321); wait_idle(); ldac_pulse();
    chk("R5 refreshed", dac_of(3), 'h321);
    chk("R5 untouched", dac_of(4), 'hABC);
    check_all("R5 outputs");
    wr(0, 0, 'h01, 'h055);
    clr_n = 1'b0; tick(); clr_n = 1'b1; tick();
    for (int i = 0; i < NCH; i++) mdac[i] = 'h055;
    check_all("R7 pin clear");

    // R6 toggle group 1 (channels 8..15)
    wr(3, 1, 10, 'h333);
    chk("R6 B rejected no busy", busy_n, 1);
    wr(0, 0, 'h0C, 'h802);
    wr(3, 0, 9, 'h111); wr(3, 1, 9, 'h222); wr(3, 0, 10, 'h444);
    wait_idle(); ldac_pulse();
    chk("R6 first A ch9", dac_of(9), 'h111);
    chk("R6 first A ch10", dac_of(10), 'h444);
    ldac_pulse();
    chk("R6 then B ch9", dac_of(9), 'h222);
    chk("R6 rejected B ch10", dac_of(10), 0);
    wr(0, 0, 'h0C, 'h800);
    ldac_pulse();
    chk("R6 back to A ch9", dac_of(9), 'h111);
    chk("R6 back to A ch10", dac_of(10), 'h444);
    mx1[9] = 'h111; mx1[10] = 'h444;
    for (int i = 8; i < 16; i++) mdac[i] = exp_x2(mx1[i], mm[i], mc[i]);
    check_all("R6 outputs");

    // R10 monitor
    wr(0, 0, 'h0A, 12 << 6); tick(2);
    chk("R10 gated", mon_sel, 63);
    wr(0, 0, 'h0C, 'h880); tick(2);
    chk("R10 enabled", mon_sel, 12);
    wr(0, 0, 'h0A, 63 << 6); tick(2);
    chk("R10 off code", mon_sel, 63);
    wr(0, 0, 'h0A, 45 << 6); tick(2);
    chk("R10 out of range", mon_sel, 63);
    wr(0, 0, 'h0A, 39 << 6); tick(2);
    chk("R10 last", mon_sel, 39);
    wr(0, 0, 'h0C, 'h800); tick(2);
    chk("R9 ctrl write", ctrl_q, 'h800);

    // R2/R5 random rounds
    for (int r = 0; r < 150; r++) begin
      int nw;
      nw = 1 + int'($urandom % 6);
      for (int k = 0; k < nw; k++) begin
        int rg, a;
        rg = 1 + int'($urandom % 3);
        a  = int'($urandom % NCH);
        if (rg == 2) wr_ch(2, a, 'h700 + int'($urandom % 'h200));
        else         wr_ch(rg, a, int'($urandom % 4096));
      end
      if ($urandom % 2) wait_idle();
      ldac_pulse();
      check_all("R2 random");
    end

    // R9 power-down, R8 ignored
    wr(0, 0, 'h08, 0);
    chk("R9 pdown", pdown, 1);
    wr(3, 0, 0, 'h777);
    chk("R9 write rejected", busy_n, 1);
    wr(0, 0, 'h0C, 'h880);
    chk("R9 ctrl frozen", ctrl_q, 'h800);
    wr(0, 0, 'h0F, 0);
    hrst = 1'b1; tick(); hrst = 1'b0; tick();
    check_all("R8 ignored in pdown");
    wr(0, 0, 'h09, 0);
    chk("R9 power up", pdown, 0);
    ldac_pulse();
    check_all("R9 no change");

    // R8 soft reset and hardware reset
    wr(0, 0, 'h0F, 0); tick();
    model_reset();
    check_all("R8 soft reset");
    chk("R8 ctrl", ctrl_q, 'h800);
    wr_ch(3, 7, 'h300); wait_idle(); ldac_pulse();
    chk("R8 m c restored", dac_of(7), 'h300);
    wr_ch(3, 2, 'h456); wait_idle(); ldac_pulse();
    chk("R8 before hrst", dac_of(2), 'h456);
    hrst = 1'b1; tick(); hrst = 1'b0; tick();
    model_reset();
    check_all("R8 hard reset");

    finished = 1;
    summary();
    $finish;
  end

  function automatic int CALC_WAIT();
    return 8;
  endfunction
endmodule